// File: doc/BRIEF.md
# Serial Receive Queue with Early Stop Signalling

This block is the receive half of a CPU-attached serial port. It watches an asynchronous line carrying frames of one start bit, eight data bits (least significant first) and one stop bit, with no parity. The bit time is a fixed number of system clocks. Each good byte is appended to a small first-in first-out queue that the CPU drains through a read strobe. By default the bit time is 434 clocks, which gives 115200 baud from a 50 MHz clock. The default queue holds 32 bytes.

A sender may keep pushing a few characters after it has been told to stop. For that reason the stop request toward the sender rises while a safety margin of free entries is still left, not when the queue fills. The CPU read strobe may stay high for several clocks. Only its rising edge removes an entry, so a byte queued behind the one being read is never lost. Sticky flags report a byte dropped because the queue was full (overrun) and a byte dropped because its stop bit was low (framing error). A status-read strobe clears both flags. The queue depth must be a power of two.

Top module: `serial_rx_queue`

## Requirements
- R1: A frame is accepted only if the line, after a falling edge, is still low at the middle of the start bit. A low pulse shorter than half a bit time produces no byte. Data bits are sampled at their centres, every CLK_PER_BIT clocks, with the least significant bit first.
- R2: Good bytes are kept in arrival order. `rx_data` always shows the oldest stored byte. `rx_avail` is 1 whenever at least one byte is stored.
- R3: An entry is removed only on the rising edge of `rd_data_stb`. Holding the strobe high for any number of clocks removes exactly one entry.
- R4: When two bytes arrive before any read, two consecutive reads return them in arrival order.
- R5: `rx_full` is 1 exactly when DEPTH bytes are stored.
- R6: `flow_stop` is 1 exactly when the number of free entries (DEPTH minus stored) is less than STOP_MARGIN.
- R7: A byte that completes while the queue is full is discarded, the stored contents are unchanged, and `overrun` is set and stays set.
- R8: A frame whose stop bit samples low is discarded and sets `frame_err`, which stays set.
- R9: The rising edge of `rd_stat_stb` clears `overrun` and `frame_err`. A new error event in the same clock takes precedence over the clear.
- R10: After reset the queue is empty and `rx_avail`, `rx_full`, `flow_stop`, `overrun` and `frame_err` are all 0.
- R11: A rising edge of `rd_data_stb` while the queue is empty has no effect. The next received byte becomes the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rd_data_stb | input | 1 | CPU data-read strobe; rising edge pops one byte |
| rd_stat_stb | input | 1 | CPU status-read strobe; rising edge clears sticky flags |
| rx_data | output | 8 | Oldest stored byte |
| rx_avail | output | 1 | Queue not empty |
| rx_full | output | 1 | Queue full |
| flow_stop | output | 1 | Request to the sender to pause (1 = stop) |
| overrun | output | 1 | Sticky: byte dropped because queue was full |
| frame_err | output | 1 | Sticky: byte dropped because stop bit was low |

## Verification
The assertions assume that both CPU strobes are synchronous to `clk`. They also assume the strobes are 0 while reset is held, so the first comparison against the previous strobe level after reset is meaningful. The bench changes every input on the falling clock edge and drives both strobes low from time zero. It drives the serial line in whole bit times of exactly CLK_PER_BIT clocks. Only the glitch test in R1 deliberately breaks the frame shape, by holding a low pulse much shorter than half a bit.

// File: rtl/serq_pkg.sv
package serq_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/serq_sampler.sv
module serq_sampler
  import serq_pkg::*;
#(
  parameter int unsigned CLK_PER_BIT = 434
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_data,
  output logic              frame_bad
);
  localparam int unsigned CNT_W   = $clog2(CLK_PER_BIT + 1);
  localparam int unsigned HALF    = CLK_PER_BIT / 2;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_PER_BIT - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF - 1);

  logic [2:0]        sync_q;
  logic              rx_s;
  logic              fall;
  rx_state_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [2:0]        bit_idx;
  logic [BYTE_W-1:0] shreg;

  assign rx_s = sync_q[1];
  assign fall = sync_q[2] & ~sync_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 3'b111;
    else        sync_q <= {sync_q[1:0], rx_line};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      byte_vld  <= 1'b0;
      frame_bad <= 1'b0;
    end else begin
      byte_vld  <= 1'b0;
      frame_bad <= 1'b0;
      case (state)
        RX_IDLE: begin
          cnt <= '0;
          if (fall) state <= RX_START;
        end
        RX_START: begin
          if (cnt == CNT_HALF) begin
            cnt     <= '0;
            bit_idx <= '0;
            state   <= rx_s ? RX_IDLE : RX_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt == CNT_LAST) begin
            cnt   <= '0;
            shreg <= {rx_s, shreg[BYTE_W-1:1]};
            if (bit_idx == 3'd7) state <= RX_STOP;
            else                 bit_idx <= bit_idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt == CNT_LAST) begin
            cnt       <= '0;
            byte_vld  <= rx_s;
            frame_bad <= ~rx_s;
            state     <= RX_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign byte_data = shreg;
endmodule

// File: rtl/serq_rise.sv
module serq_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign rise = level & ~prev_q;
endmodule

// File: rtl/serq_fifo.sv
module serq_fifo #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned FW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [FW-1:0]    fill,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             push_ok, pop_ok;

  assign full    = (fill == FW'(DEPTH));
  assign empty   = (fill == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import serq_pkg::*;
#(
  parameter int unsigned CLK_PER_BIT = 434,
  parameter int unsigned DEPTH       = 32,
  parameter int unsigned STOP_MARGIN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              rd_data_stb,
  input  logic              rd_stat_stb,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_avail,
  output logic              rx_full,
  output logic              flow_stop,
  output logic              overrun,
  output logic              frame_err
);
  localparam int unsigned FW = $clog2(DEPTH + 1);
  localparam logic [FW-1:0] STOP_AT = FW'(DEPTH - STOP_MARGIN);

  logic              byte_vld, frame_bad;
  logic [BYTE_W-1:0] byte_data;
  logic              pop_rise, stat_rise;
  logic [FW-1:0]     fill;
  logic              empty;

  serq_sampler #(.CLK_PER_BIT(CLK_PER_BIT)) u_sampler (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line),
    .byte_vld(byte_vld), .byte_data(byte_data), .frame_bad(frame_bad)
  );

  serq_rise u_pop_edge  (.clk(clk), .rst_n(rst_n), .level(rd_data_stb), .rise(pop_rise));
  serq_rise u_stat_edge (.clk(clk), .rst_n(rst_n), .level(rd_stat_stb), .rise(stat_rise));

  serq_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(byte_vld), .din(byte_data), .pop(pop_rise),
    .dout(rx_data), .fill(fill), .full(rx_full), .empty(empty)
  );

  assign rx_avail  = ~empty;
  assign flow_stop = (fill > STOP_AT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overrun   <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      if (byte_vld && rx_full) overrun <= 1'b1;
      else if (stat_rise)      overrun <= 1'b0;
      if (frame_bad)           frame_err <= 1'b1;
      else if (stat_rise)      frame_err <= 1'b0;
    end
  end
endmodule

// File: rtl/serq_checker.sv
module serq_checker #(
  parameter int unsigned FW = 6,
  parameter int unsigned DEPTH = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_data_stb,
  input logic          rd_stat_stb,
  input logic          rx_full,
  input logic          flow_stop,
  input logic          overrun,
  input logic          frame_err,
  input logic [FW-1:0] fill
);
  p_fill_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, fill} <= (FW+1)'(DEPTH));

  p_full_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> flow_stop);

  p_one_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_stb && $past(rd_data_stb)) |=> ({1'b0, fill} >= {1'b0, $past(fill)}));

  p_fill_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, fill} <= {1'b0, $past(fill)} + 1'b1) &&
    ({1'b0, $past(fill)} <= {1'b0, fill} + 1'b1));

  p_overrun_when_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_full));

  p_overrun_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overrun) |-> $past(rd_stat_stb));

  p_ferr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_err) |-> $past(rd_stat_stb));
endmodule

bind serial_rx_queue serq_checker #(.FW(FW), .DEPTH(DEPTH)) u_checker (
  .clk(clk), .rst_n(rst_n), .rd_data_stb(rd_data_stb), .rd_stat_stb(rd_stat_stb),
  .rx_full(rx_full), .flow_stop(flow_stop), .overrun(overrun),
  .frame_err(frame_err), .fill(fill)
);

// File: tb/tb_serial_rx_queue.sv
module tb_serial_rx_queue;
  localparam int CPB    = 8;
  localparam int DEPTH  = 8;
  localparam int MARGIN = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       rd_data_stb = 1'b0;
  logic       rd_stat_stb = 1'b0;
  logic [7:0] rx_data;
  logic       rx_avail, rx_full, flow_stop, overrun, frame_err;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  serial_rx_queue #(.CLK_PER_BIT(CPB), .DEPTH(DEPTH), .STOP_MARGIN(MARGIN)) dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line),
    .rd_data_stb(rd_data_stb), .rd_stat_stb(rd_stat_stb),
    .rx_data(rx_data), .rx_avail(rx_avail), .rx_full(rx_full),
    .flow_stop(flow_stop), .overrun(overrun), .frame_err(frame_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic stop_bit);
    @(negedge clk) rx_line = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_line = b[i];
      repeat (CPB) @(negedge clk);
    end
    rx_line = stop_bit;
    repeat (CPB) @(negedge clk);
    rx_line = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_data(input int hold);
    @(negedge clk) rd_data_stb = 1'b1;
    repeat (hold) @(negedge clk);
    rd_data_stb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic read_stat();
    @(negedge clk) rd_stat_stb = 1'b1;
    @(negedge clk) rd_stat_stb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R10: reset state
    chk("R10 avail", int'(rx_avail), 0);
    chk("R10 full", int'(rx_full), 0);
    chk("R10 flow_stop", int'(flow_stop), 0);
    chk("R10 overrun", int'(overrun), 0);
    chk("R10 frame_err", int'(frame_err), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 avail after release", int'(rx_avail), 0);

    // R1/R2/R3: every byte value, one at a time
    for (int v = 0; v < 256; v++) begin
      send(8'(v), 1'b1);
      chk("R1 byte value", int'(rx_data), v);
      chk("R2 avail", int'(rx_avail), 1);
      read_data(2);
      chk("R3 popped", int'(rx_avail), 0);
    end

    // R1: short low glitch ignored
    @(negedge clk) rx_line = 1'b0;
    repeat (2) @(negedge clk);
    rx_line = 1'b1;
    repeat (3 * CPB) @(negedge clk);
    chk("R1 glitch no byte", int'(rx_avail), 0);
    chk("R1 glitch no frame_err", int'(frame_err), 0);

    // R4: two queued bytes, two-cycle strobe pops only one
    send(8'h30, 1'b1);
    send(8'h78, 1'b1);
    chk("R4 head first", int'(rx_data), 'h30);
    read_data(2);
    chk("R4 second kept", int'(rx_data), 'h78);
    chk("R4 still avail", int'(rx_avail), 1);
    read_data(2);
    chk("R4 drained", int'(rx_avail), 0);

    // R3: long strobe removes exactly one
    send(8'h11, 1'b1);
    send(8'h22, 1'b1);
    send(8'h33, 1'b1);
    read_data(6);
    chk("R3 long strobe head", int'(rx_data), 'h22);
    read_data(1);
    chk("R3 next head", int'(rx_data), 'h33);
    read_data(1);
    chk("R3 empty", int'(rx_avail), 0);

    // R11: read when empty is ignored
    read_data(1);
    send(8'h42, 1'b1);
    chk("R11 head after empty read", int'(rx_data), 'h42);
    chk("R11 avail", int'(rx_avail), 1);
    read_data(1);
    chk("R11 drained", int'(rx_avail), 0);

    // R5/R6: fill sweep
    for (int k = 1; k <= DEPTH; k++) begin
      send(8'(8'hA0 + k), 1'b1);
      chk("R6 flow_stop", int'(flow_stop), ((DEPTH - k) < MARGIN) ? 1 : 0);
      chk("R5 full", int'(rx_full), (k == DEPTH) ? 1 : 0);
    end

    // R7: overrun
    send(8'h55, 1'b1);
    chk("R7 overrun set", int'(overrun), 1);
    chk("R7 head unchanged", int'(rx_data), 'hA1);
    chk("R7 still full", int'(rx_full), 1);
    read_data(1);
    chk("R7 overrun sticky", int'(overrun), 1);
    read_stat();
    chk("R9 overrun cleared", int'(overrun), 0);
    for (int k = 2; k <= DEPTH; k++) begin
      chk("R2 order", int'(rx_data), 'hA0 + k);
      read_data(2);
    end
    chk("R7 dropped byte absent", int'(rx_avail), 0);
    chk("R6 flow released", int'(flow_stop), 0);

    // R8/R9: framing error
    send(8'h99, 1'b0);
    repeat (2 * CPB) @(negedge clk);
    chk("R8 frame_err set", int'(frame_err), 1);
    chk("R8 byte dropped", int'(rx_avail), 0);
    read_stat();
    chk("R9 frame_err cleared", int'(frame_err), 0);
    send(8'h5A, 1'b1);
    chk("R8 recovers", int'(rx_data), 'h5A);
    read_data(1);

    summary();
    $finish;
  end
endmodule